// File: doc/BRIEF.md
# Reset Source Gating and Sleep Entry Control

This block holds a small system-control register that decides which reset events are allowed to reset the chip. It also decides which of those resets additionally return the I/O port configuration to its default state. Three raw event inputs arrive from elsewhere in the chip: a watchdog expiry, a bus fault and a reset request from port A. Each event is qualified against the stored enables. The block then produces a registered system-reset request and a registered port-configuration reset request.

The same register guards sleep entry. A sleep request bit is honoured only while a separate unlock bit is already set. A write that qualifies produces a one-cycle sleep-entry pulse in the same cycle as the write. The sleep request bit never reads back as one.

The watchdog reset enable is sticky. Software can set it, but only an assertion of the block's power-on reset input clears it. Its current value is driven to the watchdog timer.

Top module: `rstsrc_ctrl`

## Requirements
- R1: After power-on reset (rst_ni low), cfg_rdata_o reads 0x00, wdt_en_o is 0, and sys_rst_o, pcfg_rst_o and sleep_o are all 0. This also holds when the watchdog enable had been set before the reset.
- R2: sleep_o is 1 in the same cycle as a write (cfg_we_i=1) whose bit 4 is 1, provided bit 3 (sleep unlock) was already 1 before that write. sleep_o is 0 in the following cycle unless another such write occurs.
- R3: While the stored unlock bit is 0, a write with bit 4 set produces no sleep_o pulse. This applies even when the same write sets bit 3.
- R4: Bit 4 of cfg_rdata_o always reads 0.
- R5: Bit 0 (watchdog reset enable, also driven on wdt_en_o) is set by writing 1 to it. Writing 0 to it does not clear it.
- R6: A watchdog expiry (wdt_expire_i) raises sys_rst_o only while bit 0 is 1.
- R7: A bus fault (bus_err_i) raises sys_rst_o only while bit 1 is 1.
- R8: A port-A request (porta_rst_i) always raises sys_rst_o.
- R9: While bit 2 is 1, every reset that raises sys_rst_o also raises pcfg_rst_o in the same cycle.
- R10: While bit 2 is 0, pcfg_rst_o stays 0 whatever the events.
- R11: Bits 0 to 3 read back their stored values. Bits 7 to 5 read 0.
- R12: sys_rst_o and pcfg_rst_o follow each enabled event one clock after it is sampled. An event is judged against the enable values held before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data |
| wdt_expire_i | input | 1 | Watchdog expiry event |
| bus_err_i | input | 1 | Bus fault event |
| porta_rst_i | input | 1 | Port-A reset request |
| sys_rst_o | output | 1 | Qualified system-reset request |
| pcfg_rst_o | output | 1 | Port-configuration reset request |
| sleep_o | output | 1 | Sleep-entry pulse |
| wdt_en_o | output | 1 | Sticky watchdog reset enable |

## Verification
A register write and a reset event can land in the same clock cycle. The case that matters is a write that turns on the bus-fault enable while a bus fault is already present. The bench drives both on one edge. It expects no system reset from that event, because the enable in force is the old one. It then repeats the fault alone and expects the reset to appear one cycle later. A second collision is a single write that sets the unlock and sleep bits together. That write must give no pulse, while repeating the same write must give one.

// File: rtl/rstsrc_pkg.sv
package rstsrc_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_SRC  = 3;
  // register bit positions
  localparam int unsigned B_WDEN   = 0;
  localparam int unsigned B_BERREN = 1;
  localparam int unsigned B_PCFGEN = 2;
  localparam int unsigned B_UNLOCK = 3;
  localparam int unsigned B_SLEEP  = 4;
  // source indexes
  localparam int unsigned S_WDT    = 0;
  localparam int unsigned S_BERR   = 1;
  localparam int unsigned S_PORTA  = 2;

  typedef struct packed {
    logic unlock;
    logic pcfg_en;
    logic berr_en;
    logic wd_en;
  } ctl_t;
endpackage

// File: rtl/rstsrc_rst_sync.sv
module rstsrc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/rstsrc_regs.sv
module rstsrc_regs
  import rstsrc_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output ctl_t         ctl_o,
  output logic [W-1:0] rdata_o
);
  ctl_t ctl_q, ctl_d;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i[W-1:B_SLEEP];

  always_comb begin
    ctl_d         = ctl_q;
    ctl_d.wd_en   = ctl_q.wd_en | wdata_i[B_WDEN];
    ctl_d.berr_en = wdata_i[B_BERREN];
    ctl_d.pcfg_en = wdata_i[B_PCFGEN];
    ctl_d.unlock  = wdata_i[B_UNLOCK];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= ctl_d;
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[B_WDEN]   = ctl_q.wd_en;
    rdata_o[B_BERREN] = ctl_q.berr_en;
    rdata_o[B_PCFGEN] = ctl_q.pcfg_en;
    rdata_o[B_UNLOCK] = ctl_q.unlock;
  end

  assign ctl_o = ctl_q;

  AST_WDEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.wd_en |=> ctl_q.wd_en); // R5
  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o)); // R11
endmodule

// File: rtl/rstsrc_qual.sv
module rstsrc_qual
  import rstsrc_pkg::*;
#(
  parameter int unsigned          N      = NUM_SRC,
  parameter logic [N-1:0]         ALWAYS = 3'b100
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] en_i,
  input  logic         pcfg_en_i,
  output logic         sys_rst_o,
  output logic         pcfg_rst_o
);
  logic [N-1:0] hit;
  logic sys_d, pcfg_d, sys_q, pcfg_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    if (ALWAYS[i]) begin : g_fixed
      assign hit[i] = src_i[i];
    end else begin : g_gated
      assign hit[i] = src_i[i] & en_i[i];
    end
  end

  always_comb begin
    sys_d  = |hit;
    pcfg_d = sys_d & pcfg_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q  <= 1'b0;
      pcfg_q <= 1'b0;
    end else begin
      sys_q  <= sys_d;
      pcfg_q <= pcfg_d;
    end
  end

  assign sys_rst_o  = sys_q;
  assign pcfg_rst_o = pcfg_q;

  AST_PCFG_WITH_SYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcfg_rst_o |-> sys_rst_o); // R9
endmodule

// File: rtl/rstsrc_sleep.sv
module rstsrc_sleep (
  input  logic we_i,
  input  logic sleep_bit_i,
  input  logic unlock_q_i,
  output logic sleep_o
);
  always_comb begin
    sleep_o = we_i & sleep_bit_i & unlock_q_i;
  end
endmodule

// File: rtl/rstsrc_ctrl.sv
module rstsrc_ctrl
  import rstsrc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              wdt_expire_i,
  input  logic              bus_err_i,
  input  logic              porta_rst_i,
  output logic              sys_rst_o,
  output logic              pcfg_rst_o,
  output logic              sleep_o,
  output logic              wdt_en_o
);
  logic               rst_n;
  ctl_t               ctl;
  logic [NUM_SRC-1:0] src, en;

  rstsrc_rst_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n)
  );

  rstsrc_regs #(.W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(cfg_we_i),
    .wdata_i(cfg_wdata_i), .ctl_o(ctl), .rdata_o(cfg_rdata_o)
  );

  always_comb begin
    src          = '0;
    en           = '0;
    src[S_WDT]   = wdt_expire_i;
    src[S_BERR]  = bus_err_i;
    src[S_PORTA] = porta_rst_i;
    en[S_WDT]    = ctl.wd_en;
    en[S_BERR]   = ctl.berr_en;
  end

  rstsrc_qual #(.N(NUM_SRC), .ALWAYS(3'b100)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_n), .src_i(src), .en_i(en),
    .pcfg_en_i(ctl.pcfg_en), .sys_rst_o(sys_rst_o), .pcfg_rst_o(pcfg_rst_o)
  );

  rstsrc_sleep u_sleep (
    .we_i(cfg_we_i), .sleep_bit_i(cfg_wdata_i[B_SLEEP]),
    .unlock_q_i(ctl.unlock), .sleep_o(sleep_o)
  );

  assign wdt_en_o = ctl.wd_en;

  AST_SLEEP_NEEDS_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_n)
    sleep_o |-> cfg_rdata_o[B_UNLOCK]); // R3
  AST_SYS_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_n)
    sys_rst_o |-> $past(porta_rst_i | (bus_err_i & cfg_rdata_o[B_BERREN])
                        | (wdt_expire_i & wdt_en_o))); // R12
  AST_PCFG_GATED: assert property (@(posedge clk_i) disable iff (!rst_n)
    pcfg_rst_o |-> $past(cfg_rdata_o[B_PCFGEN])); // R10
  AST_SLEEP_NEVER_READ: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(sleep_o) |-> !cfg_rdata_o[B_SLEEP]); // R4
endmodule

// File: tb/sim_rstsrc_ctrl.sv
`timescale 1ns/1ps
module sim_rstsrc_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic wdt = 1'b0, berr = 1'b0, porta = 1'b0;
  logic sys_rst, pcfg_rst, sleep, wden;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rstsrc_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .wdt_expire_i(wdt), .bus_err_i(berr),
    .porta_rst_i(porta), .sys_rst_o(sys_rst), .pcfg_rst_o(pcfg_rst),
    .sleep_o(sleep), .wdt_en_o(wden)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, output logic pulse);
    @(negedge clk); we = 1'b1; wdata = d;
    #1 pulse = sleep;
    @(negedge clk); we = 1'b0; wdata = 8'h00;
  endtask

  task automatic ev(input logic w, input logic b, input logic p,
                    output logic s, output logic c);
    @(negedge clk); wdt = w; berr = b; porta = p;
    @(negedge clk); s = sys_rst; c = pcfg_rst;
    wdt = 1'b0; berr = 1'b0; porta = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 outs", {4'h0, sys_rst, pcfg_rst, sleep, wden}, 8'h00);
  endtask

  task automatic t_readback();
    logic p;
    wr(8'hEE, p);
    chk("R11 readback", rdata, 8'h0E);
    wr(8'h00, p);
    chk("R11 clear", rdata, 8'h00);
  endtask

  task automatic t_sleep();
    logic p;
    wr(8'h10, p);
    chk("R3 locked", {7'h0, p}, 8'h00);
    wr(8'h18, p);
    chk("R3 same write unlock", {7'h0, p}, 8'h00);
    chk("R4 read zero", rdata, 8'h08);
    wr(8'h18, p);
    chk("R2 pulse", {7'h0, p}, 8'h01);
    #1 chk("R2 one cycle", {7'h0, sleep}, 8'h00);
    chk("R4 after pulse", rdata & 8'h10, 8'h00);
    wr(8'h00, p);
  endtask

  task automatic t_sources();
    logic s, c, p;
    ev(1'b0, 1'b0, 1'b1, s, c);
    chk("R8 porta", {6'h0, s, c}, 8'h02);
    chk("R10 pcfg off", {7'h0, c}, 8'h00);
    ev(1'b0, 1'b1, 1'b0, s, c);
    chk("R7 berr gated", {6'h0, s, c}, 8'h00);
    ev(1'b1, 1'b0, 1'b0, s, c);
    chk("R6 wdt gated", {6'h0, s, c}, 8'h00);
    wr(8'h02, p);
    ev(1'b0, 1'b1, 1'b0, s, c);
    chk("R7 berr on", {6'h0, s, c}, 8'h02);
    wr(8'h06, p);
    ev(1'b0, 1'b1, 1'b0, s, c);
    chk("R9 berr pcfg", {6'h0, s, c}, 8'h03);
    ev(1'b0, 1'b0, 1'b1, s, c);
    chk("R9 porta pcfg", {6'h0, s, c}, 8'h03);
    @(negedge clk);
    chk("R12 drops", {6'h0, sys_rst, pcfg_rst}, 8'h00);
    wr(8'h00, p);
  endtask

  task automatic t_collide();
    logic s, c, p;
    @(negedge clk); we = 1'b1; wdata = 8'h02; berr = 1'b1;
    @(negedge clk); we = 1'b0; wdata = 8'h00; berr = 1'b0;
    chk("R12 old enable", {7'h0, sys_rst}, 8'h00);
    ev(1'b0, 1'b1, 1'b0, s, c);
    chk("R12 new enable", {7'h0, s}, 8'h01);
    wr(8'h00, p);
  endtask

  task automatic t_wdt();
    logic s, c, p;
    wr(8'h01, p);
    chk("R5 set", {7'h0, wden}, 8'h01);
    ev(1'b1, 1'b0, 1'b0, s, c);
    chk("R6 wdt on", {6'h0, s, c}, 8'h02);
    wr(8'h00, p);
    chk("R5 sticky", rdata, 8'h01);
    wr(8'h04, p);
    ev(1'b1, 1'b0, 1'b0, s, c);
    chk("R9 wdt pcfg", {6'h0, s, c}, 8'h03);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_readback();
    t_sleep();
    t_sources();
    t_collide();
    t_wdt();
    por();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule